// File: doc/BRIEF.md
# Tap-Delay PWM Front End

This block is the synchronous half of a high-resolution pulse-width modulator. It pairs with a programmable tapped delay element. A coarse counter runs on a clock at twice the delay element's reference frequency, so one counter period spans exactly 32 taps. From the upper bits of the duty command the block makes two registered one-cycle strobes. The set strobe starts the output pulse. The clear strobe is meant for the delay element's input. The five low bits of the duty command leave the block as a tap code, together with a load strobe. The delay element takes the code on the control-clock edge and adds that many taps to the clear strobe before the clear resets the output latch.

The duty command is captured once per period, at the last count. Before the period's clear strobe can reach the delay element, the tap code for that period has already been loaded. A command that changes part-way through a period therefore never splits a pulse. The top tap can be non-monotonic. For that case a parameter maps the 32 raw codes onto a narrower usable span.

Top module: `hrpwm_front`

## Requirements
- R1: While reset is held, the coarse count is 0, the set strobe, clear strobe and load strobe are low, and the tap code is 0.
- R2: After reset the coarse count rises by one per clock and wraps from 2^CNT_W-1 to 0, so a PWM period lasts 2^CNT_W clocks (8 at the default CNT_W=3).
- R3: The set strobe is high for exactly one clock, in the cycle when the coarse count reads 1. This happens only when the held duty command is nonzero.
- R4: The clear strobe is high for exactly one clock, in the cycle after the coarse count equalled the held upper duty bits (duty_cmd[CNT_W+4:5]), that is, when the count reads upper+1 modulo 2^CNT_W.
- R5: The load strobe is high for one clock in the cycle when the coarse count reads 0. During that cycle the tap code shows the low five bits duty_cmd[4:0] of the held command, at the default FINE_SPAN=32.
- R6: The command is captured only on the clock edge where the count wraps to 0. A change at any other time alters neither the tap code nor the strobes of the period in progress.
- R7: With the delay element applying code × (Tclk/32) to the clear strobe, the time from the set strobe's rising edge to the delayed clear equals upper × Tclk + code × Tclk/32. For example, command 8'b100_10011 gives 4 clocks plus 19 taps.
- R8: A duty command of 0 produces no set strobe, so the output never goes high.
- R9: With FINE_SPAN below 32, the tap code is floor(raw × FINE_SPAN / 32), where raw is duty_cmd[4:0]. For example, with FINE_SPAN=30 a raw code of 31 gives 29.
- R10: With the maximum upper bits, the clear strobe falls in the count-0 cycle of the following period. It uses the tap code of the period that produced it and finishes before the next set strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, twice the delay reference frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | CNT_W+5 | Duty command: upper coarse bits, low five tap bits |
| coarse_cnt | output | CNT_W | Current coarse count |
| set_pulse | output | 1 | Registered set strobe for the output latch |
| clr_pulse | output | 1 | Registered clear strobe for the delay element input |
| tap_code | output | 5 | Tap count to load into the delay element |
| tap_load | output | 1 | Load strobe for tap_code, synchronous to clk |

## Verification
Two cases are hard to reach from the ports. The first is a command change landing mid-period. The bench waits until the count shows a value in the middle of the period, then swaps the command, and checks two things: the tap code does not move, and the pulse that completes still has the old width. The second is the wrap case, where the clear strobe of a full-scale command lands in the same cycle as the next period's load. Here a behavioural delay model takes the clear strobe before it accepts the new code, and the bench checks that the width uses the old code.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
  // Width of the tap code port on the delay element (32 taps per counter clock).
  localparam int TAP_W = 5;
  localparam int TAP_N = 1 << TAP_W;

  typedef struct packed {
    logic set;
    logic clr;
  } strobe_t;

  // Map a raw fine code onto a usable span of taps: floor(raw * span / 32).
  function automatic logic [TAP_W-1:0] scale_code(input logic [TAP_W-1:0] raw,
                                                  input int unsigned span);
    int unsigned prod;
    prod = int'(raw) * span;
    return TAP_W'(prod >> TAP_W);
  endfunction

  // Coarse comparison: does the counter match the held upper duty bits.
  function automatic logic coarse_hit(input logic [15:0] cnt, input logic [15:0] upper);
    return cnt == upper;
  endfunction
endpackage

// File: rtl/hrpwm_coarse_cnt.sv
module hrpwm_coarse_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             last_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign last_cnt = (cnt == CNT_MAX);
endmodule

// File: rtl/hrpwm_period_hold.sv
module hrpwm_period_hold
  import hrpwm_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int FINE_SPAN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   last_cnt,
  input  logic [CNT_W+TAP_W-1:0] duty_cmd,
  output logic [CNT_W-1:0]       upper_q,
  output logic                   nonzero_q,
  output logic [TAP_W-1:0]       code_q,
  output logic                   load_q
);
  logic [TAP_W-1:0] raw_fine;
  logic [TAP_W-1:0] fine_mapped;

  assign raw_fine = duty_cmd[TAP_W-1:0];

  generate
    if (FINE_SPAN >= TAP_N) begin : g_full_span
      assign fine_mapped = raw_fine;
    end else begin : g_reduced_span
      assign fine_mapped = scale_code(raw_fine, FINE_SPAN);
    end
  endgenerate

  // Capture the whole command only at the period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q   <= '0;
      nonzero_q <= 1'b0;
      code_q    <= '0;
      load_q    <= 1'b0;
    end else begin
      load_q <= last_cnt;
      if (last_cnt) begin
        upper_q   <= duty_cmd[CNT_W+TAP_W-1:TAP_W];
        nonzero_q <= |duty_cmd;
        code_q    <= fine_mapped;
      end
    end
  end
endmodule

// File: rtl/hrpwm_strobe_gen.sv
module hrpwm_strobe_gen
  import hrpwm_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] upper_q,
  input  logic             nonzero_q,
  output strobe_t          strobe_q
);
  strobe_t strobe_d;

  always_comb begin
    strobe_d.set = (cnt == '0) && nonzero_q;
    strobe_d.clr = coarse_hit(16'(cnt), 16'(upper_q));
  end

  // Registering removes comparator glitches before the latch and delay line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe_d;
  end
endmodule

// File: rtl/hrpwm_front.sv
module hrpwm_front
  import hrpwm_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int FINE_SPAN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W+TAP_W-1:0] duty_cmd,
  output logic [CNT_W-1:0]       coarse_cnt,
  output logic                   set_pulse,
  output logic                   clr_pulse,
  output logic [TAP_W-1:0]       tap_code,
  output logic                   tap_load
);
  logic             last_cnt;
  logic [CNT_W-1:0] upper_q;
  logic             nonzero_q;
  strobe_t          strobe_q;

  hrpwm_coarse_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (coarse_cnt),
    .last_cnt (last_cnt)
  );

  hrpwm_period_hold #(.CNT_W(CNT_W), .FINE_SPAN(FINE_SPAN)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_cnt  (last_cnt),
    .duty_cmd  (duty_cmd),
    .upper_q   (upper_q),
    .nonzero_q (nonzero_q),
    .code_q    (tap_code),
    .load_q    (tap_load)
  );

  hrpwm_strobe_gen #(.CNT_W(CNT_W)) strobe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (coarse_cnt),
    .upper_q   (upper_q),
    .nonzero_q (nonzero_q),
    .strobe_q  (strobe_q)
  );

  assign set_pulse = strobe_q.set;
  assign clr_pulse = strobe_q.clr;
endmodule

// File: rtl/hrpwm_front_chk.sv
module hrpwm_front_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] coarse_cnt,
  input logic             set_pulse,
  input logic             clr_pulse,
  input logic [4:0]       tap_code,
  input logic             tap_load
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> coarse_cnt == CNT_W'($past(coarse_cnt) + 1'b1)); // R2
  AST_SET_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> coarse_cnt == CNT_W'(1)); // R3
  AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse); // R3
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse); // R4
  AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |-> coarse_cnt == '0); // R5
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_cnt != '0 |-> $stable(tap_code)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !set_pulse && !clr_pulse && !tap_load); // R1
endmodule

bind hrpwm_front hrpwm_front_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .coarse_cnt (coarse_cnt),
  .set_pulse  (set_pulse),
  .clr_pulse  (clr_pulse),
  .tap_code   (tap_code),
  .tap_load   (tap_load)
);

// File: tb/hrpwm_front_tb_top.sv
`timescale 1ns/1ps
module hrpwm_front_tb_top;
  localparam real TCLK   = 4.0;          // 250 MHz
  localparam real TAP_NS = TCLK / 32.0;  // 125 ps
  localparam int  NVEC   = 8;
  localparam logic [7:0] VEC_DUTY [NVEC] = '{8'b100_10011, 8'b001_00000, 8'b000_00001,
                                             8'b000_11111, 8'b111_11111, 8'b111_00000,
                                             8'b011_01010, 8'b101_00111};
  localparam int VEC_PS [NVEC] = '{18375, 4000, 125, 3875, 31875, 28000, 13250, 20875};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty = 8'h00;
  logic [2:0] cnt_m, cnt_s;
  logic       set_m, clr_m, load_m, set_s, clr_s, load_s;
  logic [4:0] code_m, code_s;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  // Delay-element and latch model state
  int  loaded = 0;
  real set_t = 0.0, prev_set_t = 0.0;
  bit  armed = 1'b0;
  real last_w = 0.0;
  int  w_cnt = 0;
  int  set_cnt = 0;

  always #(TCLK/2.0) clk = ~clk;

  hrpwm_front dut_i (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty), .coarse_cnt(cnt_m),
    .set_pulse(set_m), .clr_pulse(clr_m), .tap_code(code_m), .tap_load(load_m));

  hrpwm_front #(.FINE_SPAN(30)) dut_s (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty), .coarse_cnt(cnt_s),
    .set_pulse(set_s), .clr_pulse(clr_s), .tap_code(code_s), .tap_load(load_s));

  // Behavioural model, evaluated mid-cycle: set edge first, then the delayed
  // clear (using the code loaded so far), then the load taking effect at the next edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (set_m) begin
        prev_set_t = set_t;
        set_t = $realtime - TCLK/2.0;
        armed = 1'b1;
        set_cnt++;
      end
      if (clr_m && armed) begin
        last_w = ($realtime - TCLK/2.0 + loaded * TAP_NS) - set_t;
        armed = 1'b0;
        w_cnt++;
      end
      if (load_m) loaded = int'(code_m);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ps(input real w);
    return $rtoi(w * 1000.0 + 0.5);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input logic [7:0] d);
    @(negedge clk);
    duty = d;
    cycles(24);
  endtask

  initial begin
    #(200000.0 * TCLK);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cycles(3);
    chk(cnt_m == 3'd0 && !set_m && !clr_m && !load_m, "R1", "strobes/count in reset",
        {cnt_m, set_m, clr_m, load_m}, 0);
    chk(code_m == 5'd0, "R1", "tap code in reset", code_m, 0);
    rst_n = 1'b1;

    // R2: counter advance
    cycles(5);
    chk(cnt_m == 3'd5, "R2", "count after 5 clocks", cnt_m, 5);

    // Vector table: R7 widths, R5 code, R9 scaled code, R10 wrap case
    for (int i = 0; i < NVEC; i++) begin
      settle(VEC_DUTY[i]);
      chk(ps(last_w) == VEC_PS[i], (VEC_DUTY[i][7:5] == 3'd7) ? "R10" : "R7",
          "pulse width ps", ps(last_w), VEC_PS[i]);
      chk(code_m == VEC_DUTY[i][4:0], "R5", "tap code", code_m, VEC_DUTY[i][4:0]);
      chk(int'(code_s) == (int'(VEC_DUTY[i][4:0]) * 30) / 32, "R9", "scaled tap code",
          code_s, (int'(VEC_DUTY[i][4:0]) * 30) / 32);
    end

    // R2/R3: set strobe spacing is one period
    settle(8'b100_10011);
    chk(ps(set_t - prev_set_t) == 32000, "R2", "set spacing ps", ps(set_t - prev_set_t), 32000);
    // R3: set strobe cycle; R4: clear strobe cycle; R5: load cycle
    while (!set_m) @(negedge clk);
    chk(cnt_m == 3'd1, "R3", "count during set", cnt_m, 1);
    while (!clr_m) @(negedge clk);
    chk(cnt_m == 3'd5, "R4", "count during clear", cnt_m, 5);
    while (!load_m) @(negedge clk);
    chk(cnt_m == 3'd0, "R5", "count during load", cnt_m, 0);

    // R6: mid-period change affects neither code nor current pulse
    while (cnt_m != 3'd2) @(negedge clk);
    begin
      int w0;
      w0 = w_cnt;
      duty = 8'b010_00001;
      @(negedge clk);
      chk(code_m == 5'd19, "R6", "code after mid-period change", code_m, 19);
      while (w_cnt == w0) @(negedge clk);
      chk(ps(last_w) == 18375, "R6", "width of running period", ps(last_w), 18375);
      while (w_cnt == w0 + 1) @(negedge clk);
      chk(ps(last_w) == 8125, "R6", "width of next period", ps(last_w), 8125);
    end

    // R7: 32 consecutive codes at upper = 2, strictly monotonic
    begin
      int prev_w;
      prev_w = -1;
      for (int c = 0; c < 32; c++) begin
        settle({3'd2, 5'(c)});
        chk(ps(last_w) == 8000 + c * 125, "R7", "sweep width ps", ps(last_w), 8000 + c * 125);
        chk(ps(last_w) > prev_w, "R7", "sweep monotonic", ps(last_w), prev_w + 1);
        prev_w = ps(last_w);
      end
    end

    // R8: zero command gives no set strobe
    settle(8'h00);
    begin
      int s0;
      s0 = set_cnt;
      cycles(16);
      chk(set_cnt == s0, "R8", "set strobes with zero duty", set_cnt - s0, 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule